// File: doc/BRIEF.md
# Configurable Fine-Grain Logic Cell

This block is one programmable cell of a fine-grained reconfigurable fabric. Eight single-bit neighbour or routing signals arrive at the cell. Three independent 3-bit selects each pick one of them as a logical input. A small function core turns the three picked bits into one result. The core can act as a two-variable truth table, a 2:1 multiplexer with optional inversion of either data leg, a buffer or inverter, or a constant. The result can pass through a D flip-flop or bypass it. It can then be inverted, and it is fanned out to up to four neighbour directions, each with its own enable.

A host programs the cell through one narrow write port. One selector value loads the 8-bit function byte and the other loads the 13-bit routing word. The same host can load the flip-flop directly and can always observe it on a read pin. An asynchronous active-low clear returns the flip-flop and both configuration registers to zero. The cell has no streaming data path. All pins are plain control or level signals, so no valid/ready handshake or back-pressure applies.

Top module: `fg_logic_cell`

## Requirements
- R1: Routing word bits [2:0], [5:3] and [8:6] select, from `src_in`, logical inputs A, B and C respectively; select value k picks `src_in[k]`.
- R2: Function mode 0 (byte bits [1:0] = 0) is a truth table: the core result is function-byte bit 2 + {B,A}.
- R3: Function mode 1 is a multiplexer: the result is B xor byte bit 3 when C is 1, and A xor byte bit 2 when C is 0.
- R4: Function mode 2 is a constant equal to byte bit 2.
- R5: Function mode 3 is a buffer or inverter: A xor byte bit 2.
- R6: Byte bit 7 inverts the cell output after the register-or-bypass choice.
- R7: With byte bit 6 clear, the output follows the core combinationally in the same cycle, and the flip-flop holds its value unless the host loads it.
- R8: With byte bit 6 set, the flip-flop captures the core result on each rising clock edge, and the output shows the flip-flop.
- R9: A host flip-flop load (`reg_wr`) stores `reg_wdata` at the edge and takes priority over capture in the same cycle.
- R10: `reg_rdata` always shows the flip-flop.
- R11: `dir_out[d]` equals the cell output when routing word bit 9+d is set, and 0 otherwise.
- R12: While `clr_n` is low, the flip-flop, function byte and routing word are zero at once, without a clock edge.
- R13: `cfg_wr` with `cfg_sel`=0 loads `cfg_wdata[7:0]` as the function byte, and with `cfg_sel`=1 loads `cfg_wdata[12:0]` as the routing word. The new setting takes effect after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| clr_n | input | 1 | Asynchronous global clear, active low |
| src_in | input | 8 | Neighbour and routing sources |
| cfg_wr | input | 1 | Host configuration write strobe |
| cfg_sel | input | 1 | 0: function byte, 1: routing word |
| cfg_wdata | input | 13 | Configuration write data |
| reg_wr | input | 1 | Host load of the cell flip-flop |
| reg_wdata | input | 1 | Value for the host load |
| reg_rdata | output | 1 | Current flip-flop value |
| cell_out | output | 1 | Final cell output |
| dir_out | output | 4 | Output per direction, gated by enables |

## Verification
Two things can meet on the same edge: a host load of the flip-flop and the capture of the core result when the register is enabled. A configuration write can also land on that edge, which changes the function after the capture has used the old one. The random stimulus issues host loads, function writes and routing writes in overlapping cycles. A directed case sets up a core result of 1 while the host loads 0. The bench model applies the host value first and uses the pre-edge configuration for the capture, and the flip-flop value read on the next cycle is compared against it.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  localparam int NSRC = 8;
  localparam int SELW = $clog2(NSRC);
  localparam int NIN  = 3;
  localparam int NDIR = 4;
  localparam int RTW  = NIN * SELW + NDIR;

  typedef enum logic [1:0] {
    FM_TABLE = 2'd0,
    FM_MUX   = 2'd1,
    FM_CONST = 2'd2,
    FM_PASS  = 2'd3
  } fmode_e;

  typedef struct packed {
    logic       inv;
    logic       reg_en;
    logic [3:0] ctl;
    fmode_e     mode;
  } fn_t;
endpackage

// File: rtl/fgc_input_router.sv
module fgc_input_router #(
  parameter int NSRC = 8,
  parameter int NIN  = 3,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]     src,
  input  logic [NIN*SELW-1:0] sel,
  output logic [NIN-1:0]      pick
);
  for (genvar i = 0; i < NIN; i++) begin : g_in
    assign pick[i] = src[sel[i*SELW +: SELW]];
  end
endmodule

// File: rtl/fgc_func_core.sv
module fgc_func_core
  import fgc_pkg::*;
(
  input  fn_t        fn,
  input  logic [2:0] in,
  output logic       core
);
  always_comb begin
    unique case (fn.mode)
      FM_TABLE: core = fn.ctl[{in[1], in[0]}];
      FM_MUX:   core = in[2] ? (in[1] ^ fn.ctl[1]) : (in[0] ^ fn.ctl[0]);
      FM_CONST: core = fn.ctl[0];
      FM_PASS:  core = in[0] ^ fn.ctl[0];
      default:  core = 1'b0;
    endcase
  end
endmodule

// File: rtl/fgc_cell_reg.sv
module fgc_cell_reg (
  input  logic clk,
  input  logic clr_n,
  input  logic cap_en,
  input  logic cap_d,
  input  logic host_wr,
  input  logic host_d,
  output logic q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)       q <= 1'b0;
    else if (host_wr) q <= host_d;
    else if (cap_en)  q <= cap_d;
  end
endmodule

// File: rtl/fg_logic_cell.sv
module fg_logic_cell
  import fgc_pkg::*;
(
  input  logic            clk,
  input  logic            clr_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            cfg_wr,
  input  logic            cfg_sel,
  input  logic [RTW-1:0]  cfg_wdata,
  input  logic            reg_wr,
  input  logic            reg_wdata,
  output logic            reg_rdata,
  output logic            cell_out,
  output logic [NDIR-1:0] dir_out
);
  localparam int SELBITS = NIN * SELW;

  fn_t            fn_q;
  logic [RTW-1:0] rt_q;
  logic [NIN-1:0] picked;
  logic           core_v;
  logic           ff_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      fn_q <= '0;
      rt_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_sel) rt_q <= cfg_wdata;
      else         fn_q <= fn_t'(cfg_wdata[7:0]);
    end
  end

  fgc_input_router #(.NSRC(NSRC), .NIN(NIN)) u_router (
    .src  (src_in),
    .sel  (rt_q[SELBITS-1:0]),
    .pick (picked)
  );

  fgc_func_core u_core (
    .fn   (fn_q),
    .in   (picked),
    .core (core_v)
  );

  fgc_cell_reg u_ff (
    .clk     (clk),
    .clr_n   (clr_n),
    .cap_en  (fn_q.reg_en),
    .cap_d   (core_v),
    .host_wr (reg_wr),
    .host_d  (reg_wdata),
    .q       (ff_q)
  );

  assign reg_rdata = ff_q;
  assign cell_out  = (fn_q.reg_en ? ff_q : core_v) ^ fn_q.inv;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign dir_out[d] = rt_q[SELBITS + d] & cell_out;
  end
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
  parameter int NDIR = 4
) (
  input logic            clk,
  input logic            clr_n,
  input logic            reg_wr,
  input logic            reg_wdata,
  input logic            reg_rdata,
  input logic            cell_out,
  input logic [NDIR-1:0] dir_out,
  input logic [4:0]      fbits,
  input logic            core_val
);
  // fbits: [4] invert, [3] register enable, [2] control bit 0, [1:0] mode

  p_host_load_r9: assert property (@(posedge clk) disable iff (!clr_n)
    reg_wr |=> reg_rdata == $past(reg_wdata));

  p_hold_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (!reg_wr && !fbits[3]) |=> $stable(reg_rdata));

  p_capture_r8: assert property (@(posedge clk) disable iff (!clr_n)
    (!reg_wr && fbits[3]) |=> reg_rdata == $past(core_val));

  p_dir_gate_r11: assert property (@(posedge clk) disable iff (!clr_n)
    (dir_out & ~{NDIR{cell_out}}) == '0);

  p_const_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (fbits[1:0] == 2'd2 && !fbits[3]) |-> cell_out == (fbits[2] ^ fbits[4]));

  p_clear_r12: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> (reg_rdata == 1'b0 && fbits == 5'd0 && dir_out == '0));
endmodule

bind fg_logic_cell fgc_checker #(.NDIR(fgc_pkg::NDIR)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cell_out  (cell_out),
  .dir_out   (dir_out),
  .fbits     ({fn_q.inv, fn_q.reg_en, fn_q.ctl[0], fn_q.mode}),
  .core_val  (core_v)
);

// File: tb/fg_logic_cell_bench.sv
module fg_logic_cell_bench;
  logic        clk = 1'b0;
  logic        clr_n = 1'b0;
  logic [7:0]  src_in = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [12:0] cfg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_wdata = 1'b0;
  logic        reg_rdata;
  logic        cell_out;
  logic [3:0]  dir_out;

  int nchk = 0;
  int nfail = 0;

  // bench model state
  logic [7:0]  m_fn = '0;
  logic [12:0] m_rt = '0;
  logic        m_ff = 1'b0;

  always #5 clk = ~clk;

  fg_logic_cell u_fg_logic_cell (
    .clk(clk), .clr_n(clr_n), .src_in(src_in), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cell_out(cell_out),
    .dir_out(dir_out)
  );

  function automatic logic m_core(logic [7:0] f, logic [12:0] r, logic [7:0] s);
    logic a, b, c;
    a = s[r[2:0]];
    b = s[r[5:3]];
    c = s[r[8:6]];
    case (f[1:0])
      2'd0:    return f[2 + {b, a}];
      2'd1:    return c ? (b ^ f[3]) : (a ^ f[2]);
      2'd2:    return f[2];
      default: return a ^ f[2];
    endcase
  endfunction

  function automatic logic m_out(logic [7:0] f, logic [12:0] r, logic [7:0] s, logic ff);
    return (f[6] ? ff : m_core(f, r, s)) ^ f[7];
  endfunction

  function automatic string mode_tag(logic [7:0] f);
    if (f[6]) return "R8";
    case (f[1:0])
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic [7:0] s, logic cw, logic cs,
                      logic [12:0] cd, logic rw, logic rd);
    logic eo, core_now;
    @(negedge clk);
    src_in = s; cfg_wr = cw; cfg_sel = cs; cfg_wdata = cd;
    reg_wr = rw; reg_wdata = rd;
    #1;
    eo = m_out(m_fn, m_rt, s, m_ff);
    check(tag, {3'b0, cell_out}, {3'b0, eo});
    check("R11", dir_out, m_rt[12:9] & {4{eo}});
    check("R10", {3'b0, reg_rdata}, {3'b0, m_ff});
    @(posedge clk);
    core_now = m_core(m_fn, m_rt, s);
    if (rw)            m_ff = rd;          // R9 host load wins
    else if (m_fn[6])  m_ff = core_now;
    if (cw) begin                          // R13
      if (cs) m_rt = cd;
      else    m_fn = cd[7:0];
    end
  endtask

  task automatic async_clear();
    @(negedge clk);
    #2;
    clr_n = 1'b0;
    #1;
    m_fn = '0; m_rt = '0; m_ff = 1'b0;
    check("R12", {3'b0, reg_rdata}, 4'h0);
    check("R12", {3'b0, cell_out}, 4'h0);
    check("R12", dir_out, 4'h0);
    @(negedge clk);
    clr_n = 1'b1;
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // reset state, R12
    repeat (3) @(posedge clk);
    #1;
    check("R12", {3'b0, reg_rdata}, 4'h0);
    check("R12", {3'b0, cell_out}, 4'h0);
    check("R12", dir_out, 4'h0);
    @(negedge clk);
    clr_n = 1'b1;

    // R1/R13: pass mode on input A, sweep source select
    step("R13", 8'h00, 1'b1, 1'b0, 13'h000 | 8'h03, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      step("R13", 8'h00, 1'b1, 1'b1, {4'hF, 3'd0, 3'd0, k[2:0]}, 1'b0, 1'b0);
      step("R1", 8'h01 << k, 1'b0, 1'b0, '0, 1'b0, 1'b0);
      step("R1", ~(8'h01 << k), 1'b0, 1'b0, '0, 1'b0, 1'b0);
    end

    // R6: constant 1 inverted -> 0, then constant 0 inverted -> 1
    step("R6", 8'h55, 1'b1, 1'b0, 13'h086, 1'b0, 1'b0);
    step("R6", 8'h55, 1'b1, 1'b0, 13'h082, 1'b0, 1'b0);
    step("R6", 8'hAA, 1'b0, 1'b0, '0, 1'b0, 1'b0);

    // R8: registered AND of A,B (table 1000), routing A=src0, B=src1
    step("R8", 8'h00, 1'b1, 1'b1, {4'h5, 3'd2, 3'd1, 3'd0}, 1'b0, 1'b0);
    step("R8", 8'h03, 1'b1, 1'b0, 13'h060, 1'b0, 1'b0);
    step("R8", 8'h03, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    step("R8", 8'h01, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    step("R8", 8'h03, 1'b0, 1'b0, '0, 1'b0, 1'b0);

    // R9: capture would load 1, host loads 0 in the same cycle
    step("R9", 8'h03, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    step("R9", 8'h03, 1'b0, 1'b0, '0, 1'b0, 1'b0);

    // R7: bypass; flip-flop holds a host-loaded 1 while inputs toggle
    step("R7", 8'h03, 1'b1, 1'b0, 13'h020, 1'b1, 1'b1);
    step("R7", 8'h00, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    step("R7", 8'h03, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    step("R7", 8'h02, 1'b0, 1'b0, '0, 1'b0, 1'b0);

    // R12: asynchronous clear mid-run
    async_clear();
    step("R12", 8'hFF, 1'b0, 1'b0, '0, 1'b0, 1'b0);

    // random mix of every mode, overlapping writes
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  s;
      logic        cw, cs, rw, rd;
      logic [12:0] cd;
      s  = 8'($urandom);
      cw = ($urandom % 3) == 0;
      cs = 1'($urandom);
      cd = 13'($urandom);
      rw = ($urandom % 5) == 0;
      rd = 1'($urandom);
      step(mode_tag(m_fn), s, cw, cs, cd, rw, rd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule